// File: doc/BRIEF.md
# SPI Register-Read Slave

This block is the serial front end of a register file. An external host selects it with an active-low chip select and clocks a fixed 17-bit command into it in SPI mode 0. Every signal on the serial side is oversampled by the system clock, so SCLK must be at most one eighth of the system clock rate. The command holds a 3-bit operation code, a 5-bit register index, an 8-bit auxiliary byte that is not used, and a parity bit. When the code asks for a read and the parity is good, the block sends the index and a one-cycle strobe to a simple register-read port.

The register port answers with 32-bit data and a valid flag. Within the same frame the block returns a 34-bit answer. It begins with a ready flag, then gives the data most significant bit first, then a parity bit. A command that is corrupted or not understood gets no read and no answer. Raising chip select at any point aborts the frame.

Top module: `spi_rd_slave`

## Requirements
- R1: Command bits are taken on rising SCLK edges while `spi_cs_n` is low, in this order: operation code bits 2..0, register index bits 4..0, auxiliary bits 7..0, then one parity bit. The auxiliary byte has no effect. On a read, `rd_addr` carries the register index.
- R2: Operation code 3'b100 with good parity produces exactly one `rd_strobe` pulse, one system clock wide, for each frame.
- R3: Parity is even over all 17 command bits, so their XOR must be 0. A command that fails this check produces no strobe, and `spi_miso` stays 0 for the rest of the frame.
- R4: Any operation code other than 3'b100 produces no strobe, and `spi_miso` stays 0 for the rest of the frame.
- R5: After a valid read command, the answer bits change on falling SCLK edges. The host samples them on rising edges 18 through 51 of the frame, in this order: ready, data bits 31..0, parity.
- R6: If `rd_valid` is high on the falling edge right after command bit 17, ready is 1 and the data bits equal `rd_data` at that moment.
- R7: If `rd_valid` is low at that falling edge, ready is 0 and all 32 data bits are 0.
- R8: The answer parity bit makes the XOR of ready, the 32 data bits and the parity bit itself equal to 0.
- R9: Raising `spi_cs_n` in the middle of a frame aborts it. A partial command produces no strobe. The next frame is decoded from its first bit.
- R10: `spi_miso` is 0 while `spi_cs_n` is high and after reset.
- R11: Rising SCLK edges after edge 51 of a frame are ignored. They cause no strobe, and `spi_miso` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial command data from the host |
| spi_miso | output | 1 | Serial answer data to the host |
| rd_addr | output | 5 | Register index for the read port |
| rd_strobe | output | 1 | One-cycle read request |
| rd_data | input | 32 | Read data from the register file |
| rd_valid | input | 1 | Read data valid |

## Verification
Every register index is read once, each with a different auxiliary byte. The top indices are set up to leave the valid flag low, and the data patterns alternate in parity. This separates a correct ready flag and data word from a zeroed one, and shows a wrong parity polarity or a shift in bit order. All eight operation codes are swept, so that only the read code causes a strobe. A set of frames with a flipped parity bit shows that bad commands are rejected. Frames that are cut short, frames cut inside the answer, and frames with extra clocks show that a frame resynchronises after an abort and that edges past the end of the frame have no effect.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  // Operation code field width and the only code this slave serves.
  localparam int          OP_W    = 3;
  localparam logic [2:0]  OP_READ = 3'b100;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = d;
      end else begin : g_rest
        assign stg_d[s] = stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rd_rx.sv
module spi_rd_rx
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int AUX_W    = 8,
  parameter int TOTAL    = 51,
  parameter int CNT_W    = 6,
  localparam int CMD_BITS = OP_W + ADDR_W + AUX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              mosi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              frame_done,
  output logic [OP_W-1:0]   op_code,
  output logic [ADDR_W-1:0] reg_idx,
  output logic              par_ok
);
  localparam logic [CNT_W-1:0] CNT_LAST_CMD = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_END      = CNT_W'(TOTAL);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CMD_BITS-1:0] sr_q, sr_d;
  logic                par_q, par_d;
  logic                done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    par_d  = par_q;
    done_d = 1'b0;
    if (!cs_act) begin
      cnt_d = '0;
      par_d = 1'b0;
    end else if (sclk_rise && (cnt_q != CNT_END)) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q <= CNT_LAST_CMD) begin
        sr_d  = {sr_q[CMD_BITS-2:0], mosi};
        par_d = par_q ^ mosi;
      end
      if (cnt_q == CNT_LAST_CMD) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      par_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      par_q  <= par_d;
      done_q <= done_d;
    end
  end

  assign bit_cnt    = cnt_q;
  assign frame_done = done_q;
  assign op_code    = sr_q[CMD_BITS-1 -: OP_W];
  assign reg_idx    = sr_q[CMD_BITS-1-OP_W -: ADDR_W];
  assign par_ok     = ~par_q;
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
  parameter int DATA_W   = 32,
  localparam int RSP_BITS = DATA_W + 2,
  localparam int RCNT_W   = $clog2(RSP_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic              load,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              active
);
  localparam logic [RCNT_W-1:0] LEFT_FULL = RCNT_W'(RSP_BITS);

  logic [RSP_BITS-1:0] sr_q, sr_d;
  logic [RCNT_W-1:0]   left_q, left_d;
  logic                miso_q, miso_d;
  logic [DATA_W-1:0]   data_m;

  assign data_m = rd_valid ? rd_data : '0;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    if (!cs_act) begin
      left_d = '0;
    end else if (sclk_fall) begin
      if (load) begin
        sr_d   = {rd_valid, data_m, ^{rd_valid, data_m}};
        left_d = LEFT_FULL;
      end else if (left_q != '0) begin
        sr_d   = {sr_q[RSP_BITS-2:0], 1'b0};
        left_d = left_q - 1'b1;
      end
    end
    miso_d = (left_d != '0) && sr_d[RSP_BITS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      miso_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      miso_q <= miso_d;
    end
  end

  assign miso   = miso_q;
  assign active = (left_q != '0);
endmodule

// File: rtl/spi_rd_slave.sv
module spi_rd_slave
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int AUX_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_strobe,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid
);
  localparam int CMD_BITS = OP_W + ADDR_W + AUX_W + 1;
  localparam int RSP_BITS = DATA_W + 2;
  localparam int TOTAL    = CMD_BITS + RSP_BITS;
  localparam int CNT_W    = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_BITS);

  // Synchronised serial lines: {sclk, cs_n, mosi}
  logic [2:0] pins_s;
  logic       sclk_s, cs_n_s, mosi_s;
  logic       sclk_q;
  logic       sclk_rise, sclk_fall, cs_act;

  spi_rd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({spi_sclk, spi_cs_n, spi_mosi}),
    .q (pins_s)
  );
  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign cs_act    = ~cs_n_s;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  logic [CNT_W-1:0]  bit_cnt;
  logic              frame_done;
  logic [OP_W-1:0]   op_code;
  logic [ADDR_W-1:0] reg_idx;
  logic              par_ok;

  spi_rd_rx #(.ADDR_W(ADDR_W), .AUX_W(AUX_W), .TOTAL(TOTAL), .CNT_W(CNT_W)) u_rx (
    .clk (clk),
    .rst_n (rst_n),
    .cs_act (cs_act),
    .sclk_rise (sclk_rise),
    .mosi (mosi_s),
    .bit_cnt (bit_cnt),
    .frame_done (frame_done),
    .op_code (op_code),
    .reg_idx (reg_idx),
    .par_ok (par_ok)
  );

  // Read request and pending-answer state
  logic              strobe_q, strobe_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pend_q, pend_d;
  logic              tx_load, tx_active;

  always_comb begin
    strobe_d = frame_done && (op_code == OP_READ) && par_ok;
    addr_d   = strobe_d ? reg_idx : addr_q;
    if (!cs_act)       pend_d = 1'b0;
    else if (strobe_d) pend_d = 1'b1;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      addr_q   <= addr_d;
      pend_q   <= pend_d;
    end
  end

  assign tx_load = pend_q && (bit_cnt == CNT_CMD);

  spi_rd_tx #(.DATA_W(DATA_W)) u_tx (
    .clk (clk),
    .rst_n (rst_n),
    .cs_act (cs_act),
    .sclk_fall (sclk_fall),
    .load (tx_load),
    .rd_valid (rd_valid),
    .rd_data (rd_data),
    .miso (spi_miso),
    .active (tx_active)
  );

  assign rd_strobe = strobe_q;
  assign rd_addr   = addr_q;
endmodule

// File: rtl/spi_rd_slave_chk.sv
module spi_rd_slave_chk #(
  parameter int CNT_W    = 6,
  parameter int CMD_BITS = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             rd_strobe,
  input logic             cs_act,
  input logic             frame_done,
  input logic             tx_active,
  input logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_BITS);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe); // R2
  AST_STROBE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> $past(frame_done)); // R2
  AST_FRAME_AT_CMD_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (bit_cnt == CNT_CMD)); // R1
  AST_TX_STARTS_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> (bit_cnt == CNT_CMD)); // R5
  AST_TX_STOPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !tx_active); // R9
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso); // R10
endmodule

bind spi_rd_slave spi_rd_slave_chk #(.CNT_W(CNT_W), .CMD_BITS(CMD_BITS)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_miso (spi_miso),
  .rd_strobe (rd_strobe),
  .cs_act (cs_act),
  .frame_done (frame_done),
  .tx_active (tx_active),
  .bit_cnt (bit_cnt)
);

// File: tb/spi_rd_slave_test.sv
`timescale 1ns/1ps
module spi_rd_slave_test;
  localparam int HALF = 8;   // system clocks per SCLK half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [4:0]  rd_addr;
  logic        rd_strobe;
  logic [31:0] rd_data;
  logic        rd_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int n_strobe = 0;
  logic [4:0] last_addr = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  spi_rd_slave uut (
    .clk (clk), .rst_n (rst_n), .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi), .spi_miso (spi_miso), .rd_addr (rd_addr),
    .rd_strobe (rd_strobe), .rd_data (rd_data), .rd_valid (rd_valid)
  );

  function automatic logic [31:0] reg_val(input logic [4:0] a);
    return {a, ~a, a, ~a, a, ~a, a[0], 1'b1};
  endfunction

  // Register-file model: valid two cycles after a strobe, indices >= 28 stay invalid
  logic       hit;
  logic [4:0] haddr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; hit <= 1'b0; haddr <= '0;
    end else if (rd_strobe) begin
      rd_valid <= 1'b0; hit <= 1'b1; haddr <= rd_addr;
      n_strobe <= n_strobe + 1; last_addr <= rd_addr;
    end else if (hit) begin
      rd_valid <= (haddr < 5'd28); rd_data <= reg_val(haddr); hit <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame of nclk SCLK pulses; records answer and any high bit past pulse 51.
  task automatic run_frame(input logic [16:0] cmdw, input int nclk,
                           output logic [33:0] resp, output logic tail);
    resp = '0; tail = 1'b0;
    wait_clk(1);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      spi_mosi = (i < 17) ? cmdw[16-i] : 1'b0;
      wait_clk(HALF);
      if (i >= 17 && i <= 50) resp[33-(i-17)] = spi_miso;
      if (i > 50) tail = tail | spi_miso;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(8);
  endtask

  function automatic logic [16:0] mk_cmd(input logic [2:0] op, input logic [4:0] a,
                                         input logic [7:0] aux, input bit bad);
    return {op, a, aux, (^{op, a, aux}) ^ bad};
  endfunction

  function automatic logic [33:0] exp_resp(input logic [4:0] a);
    logic [31:0] d;
    if (a >= 5'd28) return '0;
    d = reg_val(a);
    return {1'b1, d, ^{1'b1, d}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [33:0] resp;
    logic        tail;
    int          s0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // Reset state
    check(spi_miso == 1'b0, "R10 miso after reset", 64'(spi_miso), 64'd0);
    check(rd_strobe == 1'b0 && n_strobe == 0, "R2 no strobe after reset", 64'(rd_strobe), 64'd0);

    // All register indices, varied auxiliary byte
    for (int a = 0; a < 32; a++) begin
      s0 = n_strobe;
      run_frame(mk_cmd(3'b100, 5'(a), 8'(a * 37 + 3), 1'b0), 51, resp, tail);
      check(resp == exp_resp(5'(a)), (a >= 28) ? "R7 answer invalid data" : "R6 R5 R8 answer",
            64'(resp), 64'(exp_resp(5'(a))));
      check(n_strobe == s0 + 1, "R2 one strobe per read", 64'(n_strobe - s0), 64'd1);
      check(last_addr == 5'(a), "R1 register index", 64'(last_addr), 64'(a));
      check(spi_miso == 1'b0, "R10 miso idle after frame", 64'(spi_miso), 64'd0);
    end

    // Operation code sweep
    for (int c = 0; c < 8; c++) begin
      s0 = n_strobe;
      run_frame(mk_cmd(3'(c), 5'(c * 3 + 1), 8'hA5, 1'b0), 51, resp, tail);
      if (c == 4) begin
        check(resp == exp_resp(5'(c * 3 + 1)), "R5 read code answer", 64'(resp), 64'(exp_resp(5'(c * 3 + 1))));
        check(n_strobe == s0 + 1, "R2 read code strobe", 64'(n_strobe - s0), 64'd1);
      end else begin
        check(resp == '0, "R4 other code silent", 64'(resp), 64'd0);
        check(n_strobe == s0, "R4 other code no strobe", 64'(n_strobe - s0), 64'd0);
      end
    end

    // Bad parity
    for (int a = 0; a < 8; a++) begin
      s0 = n_strobe;
      run_frame(mk_cmd(3'b100, 5'(a * 4 + 2), 8'(a), 1'b1), 51, resp, tail);
      check(resp == '0, "R3 bad parity silent", 64'(resp), 64'd0);
      check(n_strobe == s0, "R3 bad parity no strobe", 64'(n_strobe - s0), 64'd0);
    end

    // Abort inside command, then a good frame
    s0 = n_strobe;
    run_frame(mk_cmd(3'b100, 5'd13, 8'h3C, 1'b0), 9, resp, tail);
    check(n_strobe == s0, "R9 partial command no strobe", 64'(n_strobe - s0), 64'd0);
    run_frame(mk_cmd(3'b100, 5'd13, 8'h3C, 1'b0), 51, resp, tail);
    check(resp == exp_resp(5'd13), "R9 frame after abort", 64'(resp), 64'(exp_resp(5'd13)));
    check(last_addr == 5'd13, "R9 index after abort", 64'(last_addr), 64'd13);

    // Abort inside answer
    s0 = n_strobe;
    run_frame(mk_cmd(3'b100, 5'd6, 8'h00, 1'b0), 30, resp, tail);
    check(n_strobe == s0 + 1, "R9 complete command before abort", 64'(n_strobe - s0), 64'd1);
    check(spi_miso == 1'b0, "R10 miso after answer abort", 64'(spi_miso), 64'd0);

    // Extra clocks past end of frame
    s0 = n_strobe;
    run_frame(mk_cmd(3'b100, 5'd9, 8'hFF, 1'b0), 60, resp, tail);
    check(resp == exp_resp(5'd9), "R11 answer with extra clocks", 64'(resp), 64'(exp_resp(5'd9)));
    check(tail == 1'b0, "R11 miso low past frame end", 64'(tail), 64'd0);
    check(n_strobe == s0 + 1, "R11 no extra strobe", 64'(n_strobe - s0), 64'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule